// File: doc/BRIEF.md
# Four-point forward DCT pass

This block performs one pass of a separable 4x4 forward integer DCT in bit-exact fixed point. A whole 4x4 block of signed 16-bit samples enters in one transfer. Each of the four column positions goes through a butterfly and a rotation stage, and the products are rounded and narrowed back to 16 bits.

The result is written out already transposed. Feeding the output block straight back into the same block therefore performs the second pass, and the two passes together give the full 2-D transform. One valid/ready handshake carries the input block and a second carries the output block. The output sits in a register, so a result is available one cycle after it is accepted.

Top module: `fdct4_pass`

## Requirements
- R1: Input sample (row r, column c) sits at in_blk[(4r+c)*16 +: 16], signed. For column c, with x0..x3 taken from rows 0..3, the step terms are s0=x0+x3, s1=x1+x2, s2=x1-x2 and s3=x0-x3. Each is computed in 16 bits and wraps on overflow.
- R2: Coefficient 0 is (s0+s1)*11585 and coefficient 2 is (s0-s1)*11585. The sum and difference are first sign-extended to 32 bits, so they do not wrap at 16 bits.
- R3: Coefficient 1 is s3*15137 + s2*6270 and coefficient 3 is s3*6270 - s2*15137, each accumulated as a 32-bit signed value.
- R4: Every coefficient is rounded by adding 8192, shifted right arithmetically by 14 and truncated to its low 16 bits, which wrap with no saturation.
- R5: The output is transposed. Coefficient k of input column c appears at out_blk[(4c+k)*16 +: 16].
- R6: Feeding an output block back in as a new input yields the full 2-D forward transform of the original block.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_blk holds its value.
- R8: in_ready is high exactly when out_valid is low or out_ready is high. A block accepted on a clock edge appears on out_blk, with out_valid high, right after that edge.
- R9: A synchronous active-high reset clears out_valid and out_blk to zero.
- R10: A block presented while in_ready is low is not taken. It changes neither the held output nor any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block is present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_blk | input | 256 | Sixteen signed samples, row-major |
| out_valid | output | 1 | Result block is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_blk | output | 256 | Sixteen signed coefficients, transposed |

## Verification
The datapath holds no state between blocks. A wrong wiring of a lane, a constant or the rounding therefore shows up in the very block it corrupts, one cycle after acceptance, and a bit-exact comparison against an integer model catches it. Extreme inputs of ±32767 exercise the 16-bit wrap of the step terms and the 32-bit widening of the DC path. Handshake faults show up as a result that is lost, duplicated or changed while the consumer stalls, and the stall window is checked cycle by cycle.

// File: rtl/fdct4_pkg.sv
package fdct4_pkg;
  localparam int SAMPLE_W = 16;
  localparam int ACC_W    = 32;
  localparam int FRAC_W   = 14;
  localparam int PTS      = 4;
  // round(2^14 * cos(k*pi/64)) for k = 8, 16, 24
  localparam logic signed [ACC_W-1:0] K_C8  = 32'sd15137;
  localparam logic signed [ACC_W-1:0] K_C16 = 32'sd11585;
  localparam logic signed [ACC_W-1:0] K_C24 = 32'sd6270;
  typedef logic signed [SAMPLE_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0]    acc_t;
endpackage

// File: rtl/fdct4_round.sv
module fdct4_round #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int FRAC  = 14
) (
  input  logic signed [IN_W-1:0]  acc,
  output logic signed [OUT_W-1:0] res
);
  localparam logic signed [IN_W-1:0] HALF = IN_W'(1) <<< (FRAC - 1);
  logic signed [IN_W-1:0] biased;
  always_comb begin
    biased = acc + HALF;
    res    = OUT_W'(biased >>> FRAC);
  end
endmodule

// File: rtl/fdct4_lane.sv
module fdct4_lane
  import fdct4_pkg::*;
(
  input  smp_t x0,
  input  smp_t x1,
  input  smp_t x2,
  input  smp_t x3,
  output smp_t y0,
  output smp_t y1,
  output smp_t y2,
  output smp_t y3
);
  smp_t s0, s1, s2, s3;
  acc_t e0, e1, e2, e3;
  acc_t sum01, dif01;
  acc_t p0, p1, p2, p3;

  always_comb begin
    s0 = x0 + x3;
    s1 = x1 + x2;
    s2 = x1 - x2;
    s3 = x0 - x3;
    e0 = ACC_W'(s0);
    e1 = ACC_W'(s1);
    e2 = ACC_W'(s2);
    e3 = ACC_W'(s3);
    sum01 = e0 + e1;
    dif01 = e0 - e1;
    p0 = sum01 * K_C16;
    p2 = dif01 * K_C16;
    p1 = e3 * K_C8 + e2 * K_C24;
    p3 = e3 * K_C24 - e2 * K_C8;
  end

  fdct4_round #(.IN_W(ACC_W), .OUT_W(SAMPLE_W), .FRAC(FRAC_W)) u_r0 (.acc(p0), .res(y0));
  fdct4_round #(.IN_W(ACC_W), .OUT_W(SAMPLE_W), .FRAC(FRAC_W)) u_r1 (.acc(p1), .res(y1));
  fdct4_round #(.IN_W(ACC_W), .OUT_W(SAMPLE_W), .FRAC(FRAC_W)) u_r2 (.acc(p2), .res(y2));
  fdct4_round #(.IN_W(ACC_W), .OUT_W(SAMPLE_W), .FRAC(FRAC_W)) u_r3 (.acc(p3), .res(y3));
endmodule

// File: rtl/fdct4_pass.sv
module fdct4_pass
  import fdct4_pkg::*;
#(
  parameter int N  = PTS,
  parameter int DW = SAMPLE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N*N*DW-1:0]  in_blk,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [N*N*DW-1:0]  out_blk
);
  localparam int BLK_W = N * N * DW;

  logic [BLK_W-1:0] nxt_blk;
  logic             take;

  genvar c;
  generate
    for (c = 0; c < N; c++) begin : g_col
      smp_t y0, y1, y2, y3;
      fdct4_lane u_lane (
        .x0(in_blk[(0*N+c)*DW +: DW]),
        .x1(in_blk[(1*N+c)*DW +: DW]),
        .x2(in_blk[(2*N+c)*DW +: DW]),
        .x3(in_blk[(3*N+c)*DW +: DW]),
        .y0(y0), .y1(y1), .y2(y2), .y3(y3)
      );
      // transposed placement: column c becomes output row c
      assign nxt_blk[(c*N+0)*DW +: DW] = y0;
      assign nxt_blk[(c*N+1)*DW +: DW] = y1;
      assign nxt_blk[(c*N+2)*DW +: DW] = y2;
      assign nxt_blk[(c*N+3)*DW +: DW] = y3;
    end
  endgenerate

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_blk   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_blk   <= nxt_blk;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_blk)));
  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  assert_drain_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
  assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_blk == '0));
  assert_refuse_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && in_valid) |=> $stable(out_blk));
endmodule

// File: tb/fdct4_pass_bench.sv
module fdct4_pass_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [BW-1:0] in_blk = '0;
  logic [BW-1:0] out_blk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdct4_pass u_fdct4_pass (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_blk(in_blk),
    .out_valid(out_valid), .out_ready(out_ready), .out_blk(out_blk)
  );

  function automatic int w16(longint v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  function automatic int rnd(longint p);
    longint q;
    q = p + 8192;
    q = q >>> 14;
    return w16(q);
  endfunction

  function automatic logic [BW-1:0] model(logic [BW-1:0] b);
    logic [BW-1:0] r;
    r = '0;
    for (int c = 0; c < 4; c++) begin
      int x[4];
      int s0, s1, s2, s3;
      int y[4];
      for (int k = 0; k < 4; k++) x[k] = int'($signed(b[(4*k+c)*16 +: 16]));
      s0 = w16(x[0] + x[3]);
      s1 = w16(x[1] + x[2]);
      s2 = w16(x[1] - x[2]);
      s3 = w16(x[0] - x[3]);
      y[0] = rnd(longint'(s0 + s1) * 11585);
      y[2] = rnd(longint'(s0 - s1) * 11585);
      y[1] = rnd(longint'(s3) * 15137 + longint'(s2) * 6270);
      y[3] = rnd(longint'(s3) * 6270 - longint'(s2) * 15137);
      for (int k = 0; k < 4; k++) r[(4*c+k)*16 +: 16] = 16'(y[k]);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // present one block with out_ready high, check the result one cycle later
  task automatic run_one(string tag, logic [BW-1:0] b, output logic [BW-1:0] got);
    @(negedge clk);
    in_blk = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " out_valid"}, out_valid, 1'b1);
    check(tag, out_blk, model(b));
    got = out_blk;
  endtask

  function automatic logic [BW-1:0] fill(int v);
    logic [BW-1:0] r;
    for (int i = 0; i < 16; i++) r[i*16 +: 16] = 16'(v);
    return r;
  endfunction

  function automatic logic [BW-1:0] rand_blk(int mode);
    logic [BW-1:0] r;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] u;
      u = $urandom;
      case (mode)
        0: r[i*16 +: 16] = u[15:0];
        1: r[i*16 +: 16] = u[0] ? 16'sd32767 : -16'sd32767;
        default: r[i*16 +: 16] = 16'(int'(u[6:0]) - 64);
      endcase
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] got, a, b2, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check_bit("R9 out_valid", out_valid, 1'b0);
    check("R9 out_blk", out_blk, '0);
    check_bit("R8 in_ready idle", in_ready, 1'b1);

    run_one("R2 zeros", '0, got);
    run_one("R2 all +32767", fill(32767), got);      // R1 wraps s0/s1, R2 widening
    run_one("R1 all -32767", fill(-32767), got);
    a = '0; a[0 +: 16] = 16'sd32767; a[(12)*16 +: 16] = -16'sd32767;
    run_one("R3 odd extreme", a, got);               // s3 wraps
    a = '0; a[5*16 +: 16] = 16'sd100;
    run_one("R5 impulse", a, got);
    a = '0; a[0 +: 16] = 16'sd1;
    run_one("R4 rounding", a, got);
    a = '0;
    for (int i = 0; i < 16; i++) a[i*16 +: 16] = 16'(i * 1000 - 7000);
    run_one("R5 ramp", a, got);

    for (int t = 0; t < 150; t++) run_one("R4 random", rand_blk(t % 3), got);

    // R6 two passes
    for (int t = 0; t < 40; t++) begin
      a = rand_blk(t % 3);
      run_one("R6 pass1", a, got);
      run_one("R6 pass2", got, b2);
      check("R6 2-D", b2, model(model(a)));
    end

    // R7 / R10 stall
    a = rand_blk(0);
    b2 = rand_blk(0);
    @(negedge clk);
    out_ready = 1'b0; in_blk = a; in_valid = 1'b1;
    @(negedge clk);
    in_blk = b2;
    held = out_blk;
    check("R7 stalled result", held, model(a));
    for (int i = 0; i < 3; i++) begin
      check_bit("R8 in_ready low", in_ready, 1'b0);
      @(negedge clk);
      check_bit("R7 valid held", out_valid, 1'b1);
      check("R10 held block", out_blk, model(a));
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check_bit("R10 no extra output", out_valid, 1'b0);

    // R8 back-to-back
    a = rand_blk(1); b2 = rand_blk(0);
    @(negedge clk);
    in_blk = a; in_valid = 1'b1;
    @(negedge clk);
    check("R8 first", out_blk, model(a));
    check_bit("R8 ready full", in_ready, 1'b1);
    in_blk = b2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second", out_blk, model(b2));
    @(negedge clk);
    check_bit("R8 drained", out_valid, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule